// File: doc/BRIEF.md
# DMA Event and Interrupt Router

This block sits between the channel threads of a multi-channel DMA engine and the rest of the chip. Each channel thread can issue a send-event on one of seven event indices. A per-index enable bit decides where the request goes. With the bit set, the request latches a level interrupt toward the processors. With the bit clear, the request becomes a one-cycle internal event that releases every channel thread currently stalled in wait-for-event on that index.

Software reaches the block through a small register port. It can program the enables, read the pending interrupts and clear them. A separate sticky abort interrupt is raised whenever the engine reports an abort, and the enable bits do not affect it.

A send-event may carry a write-barrier flag. Such a request is held off, with its acknowledge low, until a counter of outstanding bus writes has drained to zero. The counter counts up on write issue and down on write response. Instruction decode and the bus master are outside the block; they appear only as request, acknowledge and count pulses.

Top module: `evt_irq_router`

## Requirements
- R1: After reset, all interrupt outputs are low, the abort output is low, no wake pulse is driven, and the enable, status and abort registers read 0.
- R2: A send-event accepted on an index 0..6 whose enable bit is 1 drives `irq[index]` high from the next cycle on, and it stays high.
- R3: A pending interrupt stays high until the host clears it. A wait-for-event on any index never clears it.
- R4: A host write to address 2 clears, from the next cycle, every pending bit whose write-data bit is 1. Bits written as 0 are left alone.
- R5: A send-event accepted on an index whose enable bit is 0 sets no interrupt. Instead, in the following cycle, it pulses `wake` for one cycle on every channel waiting on that index, and those channels stop waiting.
- R6: A wait-for-event is captured only when the channel is not already waiting. A waiting channel gets no wake until an event occurs on its index. A wait captured on the same clock edge as the event's acceptance is released. An event that finds no waiter is not stored.
- R7: When a host clear and a new set hit the same index in the same cycle, the index ends up pending.
- R8: Send-events from all four request ports in the same cycle are all applied in that cycle.
- R9: Register map, with 7-bit data: address 0 holds the enables (read/write, bit i = index i); address 1 is the pending status (read-only, bit i = index i); address 2 is clear (write 1 to clear, reads 0); address 3 is abort status in bit 0.
- R10: Send-events without a barrier are acknowledged at once. A send-event with the barrier flag is acknowledged only in a cycle where the outstanding-write count (up on `wr_issue`, down on `wr_resp`) is zero.
- R11: `abort_req` sets `abort_irq` from the next cycle, regardless of the enables. It stays set until any host write to address 3. If a new abort arrives in the same cycle as that write, the abort bit stays set.
- R12: A send-event on index 7 is acknowledged but changes no interrupt and wakes no channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sev_valid | input | 4 | Send-event request, one per port |
| sev_idx | input | 12 | Event index, 3 bits per port |
| sev_barrier | input | 4 | Request waits for write drain |
| sev_ack | output | 4 | Request accepted this cycle |
| wfe_valid | input | 4 | Wait-for-event, one per channel |
| wfe_idx | input | 12 | Waited index, 3 bits per channel |
| wake | output | 4 | One-cycle release of a waiting channel |
| wr_issue | input | 1 | A bus write was issued |
| wr_resp | input | 1 | A bus write response returned |
| abort_req | input | 1 | Abort condition |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 7 | Host write data |
| reg_rdata | output | 7 | Host read data |
| irq | output | 7 | Level interrupts, one per index |
| abort_irq | output | 1 | Abort interrupt |

## Verification
The bench targets several cases. A clear and a set landing on the same index in one cycle tests R7: a design that lets the clear win drops an interrupt. A wait-for-event issued while an interrupt is pending tests R3: a design that wrongly clears it lowers the output. Four ports firing at once test R8: a design that serializes or merges them loses an index. An event sent with no waiter, followed by a later wait, tests R6: a design that stores the event releases the channel at once. A barrier request is held while writes are still outstanding and a plain request is sent alongside it. This catches a design that acknowledges the barrier early, or that also blocks plain requests. An abort raised in the same cycle as its host clear checks that the abort bit is not lost.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int NUM_IDX = 7;
  localparam int IDX_W   = 3;
  localparam int REG_AW  = 2;
  localparam int REG_DW  = NUM_IDX;

  typedef enum logic [REG_AW-1:0] {
    RA_ENABLE = 2'd0,
    RA_STATUS = 2'd1,
    RA_CLEAR  = 2'd2,
    RA_ABORT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/evr_sev_gate.sv
module evr_sev_gate
  import evr_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       sev_valid,
  input  logic [NPORT-1:0]       sev_barrier,
  input  logic [NPORT*IDX_W-1:0] sev_idx,
  input  logic                   wr_issue,
  input  logic                   wr_resp,
  output logic [NPORT-1:0]       sev_ack,
  output logic [NUM_IDX-1:0]     hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             drained;

  // outstanding-write counter: next state
  always_comb begin
    cnt_en = wr_issue ^ wr_resp;
    cnt_d  = cnt_q;
    if (wr_issue && !wr_resp) cnt_d = cnt_q + 1'b1;
    else if (!wr_issue && wr_resp) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign drained = (cnt_q == '0);

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_port
      assign sev_ack[p] = sev_valid[p] & (~sev_barrier[p] | drained);
    end
  endgenerate

  // fold all accepted requests into one per-index hit vector
  always_comb begin
    hit = '0;
    for (int q = 0; q < NPORT; q++) begin
      for (int i = 0; i < NUM_IDX; i++) begin
        if (sev_ack[q] && (sev_idx[q*IDX_W +: IDX_W] == IDX_W'(i))) hit[i] = 1'b1;
      end
    end
  end

  // R10: the count cannot reach zero without a write response
  assert_drain_needs_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) && !wr_resp |=> (cnt_q != '0));

  // R10: environment keeps the counter in range
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_resp && !wr_issue |-> (cnt_q != '0));
endmodule

// File: rtl/evr_wait_tracker.sv
module evr_wait_tracker
  import evr_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       wfe_valid,
  input  logic [NCH*IDX_W-1:0] wfe_idx,
  input  logic [NUM_IDX-1:0]   evt_q,
  output logic [NCH-1:0]       wake
);
  localparam int EXT = 1 << IDX_W;

  logic [EXT-1:0] evt_ext;
  assign evt_ext = EXT'(evt_q);

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic             wait_q, wait_d, wait_en, cap;
      logic [IDX_W-1:0] widx_q;

      assign wake[c] = wait_q & evt_ext[widx_q];

      always_comb begin
        cap     = ~wait_q & wfe_valid[c];
        wait_en = wake[c] | cap;
        wait_d  = ~wake[c];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wait_q <= 1'b0;
          widx_q <= '0;
        end else begin
          if (wait_en) wait_q <= wait_d;
          if (cap) widx_q <= wfe_idx[c*IDX_W +: IDX_W];
        end
      end

      // R5: a released channel is no longer waiting
      assert_wake_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake[c] |=> !wait_q);

      // R6: a waiting channel stays stalled until its event occurs
      assert_stall_until_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q && !wake[c] |=> wait_q);
    end
  endgenerate
endmodule

// File: rtl/evr_irq_regs.sv
module evr_irq_regs
  import evr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IDX-1:0] hit,
  input  logic               abort_req,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_DW-1:0]  reg_wdata,
  output logic [REG_DW-1:0]  reg_rdata,
  output logic [NUM_IDX-1:0] irq,
  output logic               abort_irq,
  output logic [NUM_IDX-1:0] evt_q
);
  logic [NUM_IDX-1:0] en_q, en_d;
  logic [NUM_IDX-1:0] pend_q, pend_d;
  logic [NUM_IDX-1:0] evt_d;
  logic [NUM_IDX-1:0] set_bits, clr_bits;
  logic               en_we, pend_en;
  logic               abort_q, abort_d, abort_en, abort_clr;

  // next-state logic
  always_comb begin
    en_we     = reg_wr && (reg_addr == RA_ENABLE);
    en_d      = reg_wdata[NUM_IDX-1:0];
    clr_bits  = (reg_wr && (reg_addr == RA_CLEAR)) ? reg_wdata[NUM_IDX-1:0] : '0;
    set_bits  = hit & en_q;
    evt_d     = hit & ~en_q;
    pend_d    = (pend_q & ~clr_bits) | set_bits;
    pend_en   = |(clr_bits | set_bits);
    abort_clr = reg_wr && (reg_addr == RA_ABORT);
    abort_d   = abort_req;
    abort_en  = abort_req | abort_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pend_q  <= '0;
      evt_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_d;
      if (pend_en) pend_q <= pend_d;
      evt_q <= evt_d;
      if (abort_en) abort_q <= abort_d;
    end
  end

  // host read mux
  always_comb begin
    unique case (reg_addr)
      RA_ENABLE: reg_rdata = REG_DW'(en_q);
      RA_STATUS: reg_rdata = REG_DW'(pend_q);
      RA_ABORT:  reg_rdata = REG_DW'(abort_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign irq       = pend_q;
  assign abort_irq = abort_q;

  assert_set_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bits != '0) |=> ((pend_q & $past(set_bits)) == $past(set_bits)));

  assert_pend_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~clr_bits)) == $past(pend_q & ~clr_bits)));

  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_bits & clr_bits) != '0) |=> ((pend_q & $past(set_bits & clr_bits)) == $past(set_bits & clr_bits)));

  assert_abort_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q && !abort_clr |=> abort_q);

  assert_event_not_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q != '0) |-> ((pend_q & evt_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import evr_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int NCH   = 4,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       sev_valid,
  input  logic [NPORT*IDX_W-1:0] sev_idx,
  input  logic [NPORT-1:0]       sev_barrier,
  output logic [NPORT-1:0]       sev_ack,
  input  logic [NCH-1:0]         wfe_valid,
  input  logic [NCH*IDX_W-1:0]   wfe_idx,
  output logic [NCH-1:0]         wake,
  input  logic                   wr_issue,
  input  logic                   wr_resp,
  input  logic                   abort_req,
  input  logic                   reg_wr,
  input  logic [REG_AW-1:0]      reg_addr,
  input  logic [REG_DW-1:0]      reg_wdata,
  output logic [REG_DW-1:0]      reg_rdata,
  output logic [NUM_IDX-1:0]     irq,
  output logic                   abort_irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_IDX-1:0] hit;
  logic [NUM_IDX-1:0] evt_q;

  evr_sev_gate #(.NPORT(NPORT), .CNT_W(CNT_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sev_valid  (sev_valid),
    .sev_barrier(sev_barrier),
    .sev_idx    (sev_idx),
    .wr_issue   (wr_issue),
    .wr_resp    (wr_resp),
    .sev_ack    (sev_ack),
    .hit        (hit)
  );

  evr_irq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hit      (hit),
    .abort_req(abort_req),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .abort_irq(abort_irq),
    .evt_q    (evt_q)
  );

  evr_wait_tracker #(.NCH(NCH)) u_wait (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wfe_valid(wfe_valid),
    .wfe_idx  (wfe_idx),
    .evt_q    (evt_q),
    .wake     (wake)
  );

  // R12: a request on the unused index neither raises an interrupt nor an event
  assert_idx7_inert_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hit == '0) |=> ((irq & ~$past(irq)) == '0) && (evt_q == '0));
endmodule

// File: tb/tb_evt_irq_router.sv
module tb_evt_irq_router;
  localparam int NP = 4, NC = 4, NI = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [NP-1:0]   sev_valid, sev_barrier, sev_ack;
  logic [NP*3-1:0] sev_idx;
  logic [NC-1:0]   wfe_valid, wake;
  logic [NC*3-1:0] wfe_idx;
  logic wr_issue, wr_resp, abort_req, reg_wr;
  logic [1:0] reg_addr;
  logic [6:0] reg_wdata, reg_rdata, irq;
  logic abort_irq;

  evt_irq_router dut (
    .clk(clk), .rst_n(rst_n), .sev_valid(sev_valid), .sev_idx(sev_idx),
    .sev_barrier(sev_barrier), .sev_ack(sev_ack), .wfe_valid(wfe_valid),
    .wfe_idx(wfe_idx), .wake(wake), .wr_issue(wr_issue), .wr_resp(wr_resp),
    .abort_req(abort_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .abort_irq(abort_irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic [6:0] irq;
    logic [3:0] wake;
    logic       abort;
    string      tag;
  } exp_t;
  exp_t sb[$];
  exp_t e;

  // reference model state
  logic [6:0] m_en, m_pend;
  logic       m_abort;
  int         m_cnt;
  logic [3:0] m_wait, m_wake_prev;
  logic [2:0] m_widx [4];

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // driver: predicts the outputs after the coming edge and queues them
  task automatic tick(string tag);
    logic [3:0] acc, wk;
    logic [6:0] hit, clr, evt;
    #1;
    for (int p = 0; p < NP; p++) acc[p] = sev_valid[p] && (!sev_barrier[p] || m_cnt == 0);
    checks++;
    if (sev_ack !== acc) begin
      fails++;
      $display("FAIL %s sev_ack actual=%b expected=%b", tag, sev_ack, acc);
    end
    hit = '0;
    for (int p = 0; p < NP; p++)
      if (acc[p] && sev_idx[p*3 +: 3] < 3'd7) hit[sev_idx[p*3 +: 3]] = 1'b1;
    clr = (reg_wr && reg_addr == 2'd2) ? reg_wdata : 7'd0;
    evt = hit & ~m_en;
    for (int c = 0; c < NC; c++) begin
      if (m_wake_prev[c]) m_wait[c] = 1'b0;
      else if (!m_wait[c] && wfe_valid[c]) begin
        m_wait[c] = 1'b1;
        m_widx[c] = wfe_idx[c*3 +: 3];
      end
    end
    for (int c = 0; c < NC; c++) wk[c] = m_wait[c] && (m_widx[c] < 3'd7) && evt[m_widx[c]];
    m_pend = (m_pend & ~clr) | (hit & m_en);
    if (reg_wr && reg_addr == 2'd0) m_en = reg_wdata;
    if (abort_req) m_abort = 1'b1;
    else if (reg_wr && reg_addr == 2'd3) m_abort = 1'b0;
    m_cnt = m_cnt + int'(wr_issue) - int'(wr_resp);
    m_wake_prev = wk;
    sb.push_back('{m_pend, wk, m_abort, tag});
    @(negedge clk);
    sev_valid = sev_valid & ~acc;
    wfe_valid = '0; wr_issue = 0; wr_resp = 0; reg_wr = 0; abort_req = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [6:0] exp, string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s rdata[%0d] actual=%h expected=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [6:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic sev(int p, logic [2:0] idx, logic bar);
    sev_valid[p] = 1; sev_idx[p*3 +: 3] = idx; sev_barrier[p] = bar;
  endtask

  task automatic wfe(int c, logic [2:0] idx);
    wfe_valid[c] = 1; wfe_idx[c*3 +: 3] = idx;
  endtask

  // monitor: compares registered outputs shortly after each edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (irq !== e.irq || wake !== e.wake || abort_irq !== e.abort) begin
        fails++;
        $display("FAIL %s irq/wake/abort actual=%b/%b/%b expected=%b/%b/%b",
                 e.tag, irq, wake, abort_irq, e.irq, e.wake, e.abort);
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0;
    sev_valid = '0; sev_barrier = '0; sev_idx = '0;
    wfe_valid = '0; wfe_idx = '0;
    wr_issue = 0; wr_resp = 0; abort_req = 0;
    reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    m_en = '0; m_pend = '0; m_abort = 0; m_cnt = 0; m_wait = '0; m_wake_prev = '0;
    for (int c = 0; c < NC; c++) m_widx[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    checks++;
    if (irq !== 7'd0 || abort_irq !== 1'b0 || wake !== 4'd0) begin
      fails++;
      $display("FAIL R1 outputs actual=%b/%b/%b expected=0/0/0", irq, abort_irq, wake);
    end
    rd(2'd0, 7'h00, "R1 enable");
    rd(2'd1, 7'h00, "R1 status");
    rd(2'd3, 7'h00, "R1 abort");

    // R9 enable indices 0..3 as interrupts, 4..6 as internal events
    wr(2'd0, 7'h0F); tick("R9 enable write");
    rd(2'd0, 7'h0F, "R9 enable readback");

    sev(0, 3'd2, 0); tick("R2 set idx2");
    wfe(0, 3'd5); tick("R3 wfe keeps irq");
    tick("R6 stalled"); tick("R6 stalled");
    sev(1, 3'd5, 0); tick("R5 wake ch0");
    tick("R5 wake one cycle");

    // R8 four ports in one cycle, one of them an event
    wfe(1, 3'd4); tick("R8 setup");
    sev(0, 3'd0, 0); sev(1, 3'd1, 0); sev(2, 3'd3, 0); sev(3, 3'd4, 0);
    tick("R8 four ports");
    tick("R8 after");
    rd(2'd1, 7'h0F, "R9 status");

    wr(2'd2, 7'h04); tick("R4 clear idx2");
    rd(2'd1, 7'h0B, "R4 status after clear");
    rd(2'd2, 7'h00, "R9 clear reads zero");

    wr(2'd2, 7'h01); sev(0, 3'd0, 0); tick("R7 set wins");
    rd(2'd1, 7'h0B, "R7 status");

    sev(2, 3'd7, 0); tick("R12 idx7 ignored");
    rd(2'd1, 7'h0B, "R12 status");

    // R10 barrier
    wr_issue = 1; tick("R10 issue");
    wr_issue = 1; tick("R10 issue");
    wr(2'd2, 7'h08); tick("R10 clear idx3");
    sev(0, 3'd3, 1); sev(1, 3'd2, 0); tick("R10 held, plain passes");
    tick("R10 held");
    wr_resp = 1; tick("R10 held one left");
    wr_resp = 1; tick("R10 held last resp");
    tick("R10 released");
    tick("R10 after");
    rd(2'd1, 7'h0F, "R10 status");

    // R11 abort
    abort_req = 1; tick("R11 abort set");
    rd(2'd3, 7'h01, "R11 abort status");
    wr(2'd3, 7'h00); abort_req = 1; tick("R11 set beats clear");
    rd(2'd3, 7'h01, "R11 still set");
    wr(2'd3, 7'h00); tick("R11 clear");
    rd(2'd3, 7'h00, "R11 cleared");

    // R6 event not stored, same-edge wait released
    sev(0, 3'd6, 0); tick("R6 event no waiter");
    wfe(2, 3'd6); tick("R6 late wait");
    tick("R6 not stored"); tick("R6 not stored");
    wfe(3, 3'd6); sev(0, 3'd6, 0); tick("R6 same edge");
    tick("R6 both released");
    tick("R3 final"); tick("drain");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule